// File: doc/BRIEF.md
# Sequential Instruction Prefetch Buffer

This block sits between a processor's instruction-fetch port and a 32-bit flash array that may be slower than the core clock. The core asks for either a 16-bit or a 32-bit instruction. The block keeps two full 32-bit words from flash. When a requested word is not held, the block reads the whole word from flash and returns the halfword or word that was asked for. When the core fetches from a word that is held, the block starts the flash read of the next sequential word in the same cycle. Straight-line 16-bit code therefore waits for flash only on its first fetch.

The CPU side is a request/ready handshake. The core holds `cpu_req`, `cpu_addr` and `cpu_size` until it sees `cpu_ready`. Data on `cpu_rdata` is valid in that same cycle. The flash side issues a one-cycle `fl_rd` strobe with a word address and then waits for a programmable number of wait states before it takes the data. A fetch that falls outside both held words and the word in flight drops the buffered contents. Any speculative read still running is let finish and its data is thrown away, and fetching restarts at the new address.

Top module: `fetch_prefetch_buf`

## Requirements
- R1: Reset clears both buffered entries and any flash read in flight. In the cycle after reset, `cpu_ready` and `fl_rd` are low, and the first fetch after reset always reads flash, even for a word that was held before reset.
- R2: A fetch of a word that is not held reads that full word from flash. `cpu_size`=0 requests a halfword: `cpu_addr` bit 1 = 0 returns bits 15:0 of the word, bit 1 = 1 returns bits 31:16, and the halfword is zero-extended onto `cpu_rdata[15:0]`.
- R3: A fetch of either halfword of a held word is answered without any flash read, with `cpu_ready` high in the cycle after the request is first presented.
- R4: Serving a fetch from a held word, while no read is in flight and the next sequential word is not held, issues the flash read of that next word. With `wait_states` at 2, a run of sequential halfword fetches stalls only on its first fetch.
- R5: `cpu_size`=1 requests a word-aligned 32-bit fetch and returns the whole word. If that word is still being read from flash, the block waits for the read to finish and does not issue a second read.
- R6: Flash data is taken exactly `wait_states` cycles after the cycle in which `fl_rd` is high. `fl_addr` does not change while a read is in flight, and reads never overlap. A demand miss with nothing in flight raises `cpu_ready` 3 + `wait_states` cycles after the request is first presented.
- R7: A fetch of a word that is neither held nor in flight invalidates both entries. Any read in flight is completed and its data is discarded, and then a single flash read of the new word is issued.
- R8: `cpu_ready` is a single-cycle pulse that only follows a cycle with `cpu_req` high. Each request receives exactly one ready, and the block ignores `cpu_req` in the cycle where `cpu_ready` is high.
- R9: Both entries are in use at once. While the word after the current one is being prefetched, the previous word is still held, and a fetch back into it is a hit with no flash read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Fetch request, held until `cpu_ready` |
| cpu_addr | input | ADDR_W | Byte address of the fetch |
| cpu_size | input | 1 | 0 = 16-bit fetch, 1 = 32-bit fetch |
| cpu_ready | output | 1 | Fetch complete, data valid this cycle |
| cpu_rdata | output | 32 | Fetched instruction (halfword zero-extended) |
| wait_states | input | WS_W | Flash wait states per read |
| fl_rd | output | 1 | One-cycle flash read strobe |
| fl_addr | output | ADDR_W-2 | Flash word address, held during a read |
| fl_rdata | input | 32 | Flash read data |

## Verification
The bench walks a straight-line halfword run and times every ready. A design that forgot to prefetch, or started the prefetch late, would add stall cycles after the first fetch. A design that re-read flash for the second halfword would show an extra `fl_rd`. A 32-bit fetch that lands on a word still in flight checks that the block waits rather than issuing a duplicate read. A jump made while a speculative read is pending checks that stale data is dropped: a design that captured it would return the wrong instruction or answer too early. A reset taken mid-read and a fetch back into the older of the two held words check that entry validity and replacement are handled correctly.

// File: rtl/pfb_pkg.sv
`timescale 1ns/1ps
package pfb_pkg;

  typedef enum logic {
    FS_HALF = 1'b0,
    FS_WORD = 1'b1
  } fsize_e;

  function automatic logic [31:0] pick_fetch(input logic [31:0] word,
                                             input logic        is_word,
                                             input logic        upper);
    if (is_word)    return word;
    else if (upper) return {16'h0000, word[31:16]};
    else            return {16'h0000, word[15:0]};
  endfunction

endpackage

// File: rtl/pfb_entries.sv
`timescale 1ns/1ps
module pfb_entries #(
  parameter int WORD_AW = 14,
  parameter int N_ENT   = 2,
  parameter int DW      = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               wr_en,
  input  logic [WORD_AW-1:0] wr_word,
  input  logic [DW-1:0]      wr_data,
  input  logic [WORD_AW-1:0] look_word,
  output logic               look_hit,
  output logic [DW-1:0]      look_data,
  input  logic [WORD_AW-1:0] next_word,
  output logic               next_hit
);
  localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  logic [N_ENT-1:0]   vld;
  logic [WORD_AW-1:0] tag [N_ENT];
  logic [DW-1:0]      dat [N_ENT];
  logic [N_ENT-1:0]   look_m, next_m;
  logic [IW-1:0]      victim;
  logic               vfound;
  logic [WORD_AW-1:0] pred_word;

  assign pred_word = wr_word - 1'b1;

  // Replacement: a free entry first, otherwise any entry that does not hold
  // the predecessor of the incoming word (the one the core is running in).
  always_comb begin
    victim = '0;
    vfound = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      if (!vfound && !vld[i]) begin
        victim = IW'(i);
        vfound = 1'b1;
      end
    end
    for (int i = 0; i < N_ENT; i++) begin
      if (!vfound && tag[i] != pred_word) begin
        victim = IW'(i);
        vfound = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      vld <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < N_ENT; i++)
        if (victim == IW'(i)) vld[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int i = 0; i < N_ENT; i++) begin
        if (victim == IW'(i)) begin
          tag[i] <= wr_word;
          dat[i] <= wr_data;
        end
      end
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_match
    assign look_m[g] = vld[g] && (tag[g] == look_word);
    assign next_m[g] = vld[g] && (tag[g] == next_word);
  end

  always_comb begin
    look_data = '0;
    for (int i = 0; i < N_ENT; i++)
      if (look_m[i]) look_data = look_data | dat[i];
  end

  assign look_hit = |look_m;
  assign next_hit = |next_m;

endmodule

// File: rtl/pfb_flash_seq.sv
`timescale 1ns/1ps
module pfb_flash_seq #(
  parameter int WORD_AW = 14,
  parameter int WS_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               issue,
  input  logic [WORD_AW-1:0] issue_word,
  input  logic [WS_W-1:0]    wait_states,
  input  logic               cancel,
  output logic               busy,
  output logic [WORD_AW-1:0] busy_word,
  output logic               done,
  output logic               fl_rd,
  output logic [WORD_AW-1:0] fl_addr
);
  logic              busy_q, kill_q, rd_q;
  logic [WS_W-1:0]   cnt_q;
  logic [WORD_AW-1:0] addr_q;
  logic              last;

  assign last = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      kill_q <= 1'b0;
      rd_q   <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else begin
      rd_q <= issue;
      if (issue) begin
        busy_q <= 1'b1;
        kill_q <= 1'b0;
        cnt_q  <= wait_states;
        addr_q <= issue_word;
      end else if (busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
          kill_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
          if (cancel) kill_q <= 1'b1;
        end
      end
    end
  end

  assign busy      = busy_q;
  assign busy_word = addr_q;
  assign done      = last && !kill_q;
  assign fl_rd     = rd_q;
  assign fl_addr   = addr_q;

endmodule

// File: rtl/fetch_prefetch_buf.sv
`timescale 1ns/1ps
module fetch_prefetch_buf #(
  parameter int ADDR_W = 16,
  parameter int WS_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_size,
  output logic              cpu_ready,
  output logic [31:0]       cpu_rdata,
  input  logic [WS_W-1:0]   wait_states,
  output logic              fl_rd,
  output logic [ADDR_W-3:0] fl_addr,
  input  logic [31:0]       fl_rdata
);
  import pfb_pkg::*;

  localparam int WORD_AW = ADDR_W - 2;
  localparam int N_ENT   = 2;

  logic               ready_q;
  logic [31:0]        rdata_q;
  logic [WORD_AW-1:0] req_word, nxt_word, iss_word;
  logic               active, hit, nxt_hit, serve, pend_match;
  logic               miss_go, pf_go, cancel, issue;
  logic               sq_busy, sq_done;
  logic [WORD_AW-1:0] sq_word;
  logic [31:0]        hit_data;
  logic               unused_addr_b0;

  assign unused_addr_b0 = cpu_addr[0];
  assign req_word = cpu_addr[ADDR_W-1:2];
  assign nxt_word = req_word + 1'b1;

  // The held request is ignored while its ready is being shown.
  assign active     = cpu_req && !ready_q;
  assign serve      = active && hit;
  assign pend_match = sq_busy && (sq_word == req_word);
  assign miss_go    = active && !hit && !sq_busy;
  assign cancel     = active && !hit && sq_busy && !pend_match;
  assign pf_go      = serve && !sq_busy && !nxt_hit;
  assign issue      = miss_go || pf_go;
  assign iss_word   = miss_go ? req_word : nxt_word;

  pfb_entries #(.WORD_AW(WORD_AW), .N_ENT(N_ENT), .DW(32)) u_ent (
    .clk       (clk),
    .rst       (rst),
    .clr       (miss_go),
    .wr_en     (sq_done),
    .wr_word   (sq_word),
    .wr_data   (fl_rdata),
    .look_word (req_word),
    .look_hit  (hit),
    .look_data (hit_data),
    .next_word (nxt_word),
    .next_hit  (nxt_hit)
  );

  pfb_flash_seq #(.WORD_AW(WORD_AW), .WS_W(WS_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .issue       (issue),
    .issue_word  (iss_word),
    .wait_states (wait_states),
    .cancel      (cancel),
    .busy        (sq_busy),
    .busy_word   (sq_word),
    .done        (sq_done),
    .fl_rd       (fl_rd),
    .fl_addr     (fl_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      ready_q <= serve;
      if (serve)
        rdata_q <= pick_fetch(hit_data, cpu_size == FS_WORD, cpu_addr[1]);
    end
  end

  assign cpu_ready = ready_q;
  assign cpu_rdata = rdata_q;

endmodule

// File: rtl/pfb_checker.sv
`timescale 1ns/1ps
module pfb_checker #(
  parameter int WORD_AW = 14
) (
  input logic               clk,
  input logic               rst,
  input logic               cpu_req,
  input logic               cpu_ready,
  input logic               fl_rd,
  input logic               busy,
  input logic [WORD_AW-1:0] fl_addr
);
  // R1: reset leaves the block quiet on both sides
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!cpu_ready && !fl_rd));

  // R8: ready is a one-cycle pulse
  a_r8_ready_single: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  // R8: ready only answers a request
  a_r8_ready_has_req: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> $past(cpu_req));

  // R6: address held for the whole read
  a_r6_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !fl_rd) |-> $stable(fl_addr));

  // R6: reads never overlap
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
    fl_rd |=> !fl_rd);

  // R4: a read (demand or prefetch) starts only from idle
  a_r4_issue_idle: assert property (@(posedge clk) disable iff (rst)
    fl_rd |-> !$past(busy));

endmodule

bind fetch_prefetch_buf pfb_checker #(.WORD_AW(WORD_AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_req   (cpu_req),
  .cpu_ready (cpu_ready),
  .fl_rd     (fl_rd),
  .busy      (sq_busy),
  .fl_addr   (fl_addr)
);

// File: tb/sim_fetch_prefetch_buf.sv
`timescale 1ns/1ps
module sim_fetch_prefetch_buf;
  localparam int ADDR_W = 16;
  localparam int WS_W   = 4;
  localparam int WAW    = ADDR_W - 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cpu_req = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic              cpu_size = 1'b0;
  logic              cpu_ready;
  logic [31:0]       cpu_rdata;
  logic [WS_W-1:0]   ws = 4'd2;
  logic              fl_rd;
  logic [WAW-1:0]    fl_addr;
  logic [31:0]       fl_rdata;

  int checks = 0;
  int errors = 0;
  int rdcnt  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  fetch_prefetch_buf #(.ADDR_W(ADDR_W), .WS_W(WS_W)) u0 (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_size(cpu_size), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .wait_states(ws), .fl_rd(fl_rd), .fl_addr(fl_addr), .fl_rdata(fl_rdata)
  );

  function automatic logic [31:0] fdat(input logic [WAW-1:0] w);
    logic [15:0] l;
    l = 16'(w);
    return {l ^ 16'hA5A5, l};
  endfunction

  function automatic logic [31:0] exp_data(input logic [ADDR_W-1:0] a, input logic sz);
    logic [31:0] d;
    d = fdat(a[ADDR_W-1:2]);
    if (sz)        return d;
    else if (a[1]) return {16'h0000, d[31:16]};
    else           return {16'h0000, d[15:0]};
  endfunction

  // Flash model: garbage until wait_states cycles after the strobe cycle.
  logic [3:0] mcnt;
  always_ff @(posedge clk) begin
    if (rst)                mcnt <= '0;
    else if (fl_rd)         mcnt <= 4'd1;
    else if (mcnt != 4'hF)  mcnt <= mcnt + 4'd1;
  end
  assign fl_rdata = ((fl_rd && ws == '0) || (!fl_rd && mcnt >= ws))
                    ? fdat(fl_addr) : 32'hDEAD_BEEF;

  always_ff @(posedge clk) if (fl_rd) rdcnt <= rdcnt + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic fetch(input logic [ADDR_W-1:0] a, input logic sz,
                       output int lat, output logic [31:0] d, output int reads);
    int n, r0;
    r0 = rdcnt;
    cpu_req = 1'b1; cpu_addr = a; cpu_size = sz;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cpu_ready && n < 200);
    d = cpu_rdata; reads = rdcnt - r0; lat = n;
    cpu_req = 1'b0;
    if (n >= 200) check(1'b0, "R8", "fetch watchdog", n, 0);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  typedef struct packed {
    logic [15:0] addr;
    logic        sz;
    logic [3:0]  lat;   // 0 = latency not checked
    logic [1:0]  rd;
    logic [3:0]  req;
  } vec_t;

  // wait_states = 2 throughout
  localparam vec_t TBL [12] = '{
    '{16'h0100, 1'b0, 4'd5, 2'd1, 4'd2},  // R2 cold miss
    '{16'h0102, 1'b0, 4'd1, 2'd0, 4'd3},  // R3 other half
    '{16'h0104, 1'b0, 4'd1, 2'd0, 4'd4},  // R4 prefetched
    '{16'h0106, 1'b0, 4'd1, 2'd0, 4'd4},
    '{16'h0108, 1'b0, 4'd1, 2'd0, 4'd4},
    '{16'h010A, 1'b0, 4'd1, 2'd0, 4'd4},
    '{16'h010C, 1'b1, 4'd1, 2'd0, 4'd5},  // R5 word hit
    '{16'h0110, 1'b1, 4'd3, 2'd0, 4'd5},  // R5 word still in flight
    '{16'h0202, 1'b0, 4'd7, 2'd1, 4'd7},  // R7 jump over pending prefetch
    '{16'h0200, 1'b0, 4'd1, 2'd0, 4'd3},
    '{16'h0100, 1'b0, 4'd5, 2'd1, 4'd7},  // R7 old word was dropped
    '{16'h0102, 1'b0, 4'd1, 2'd0, 4'd3}
  };

  initial begin
    int lat, rd;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!cpu_ready, "R1", "ready after reset", cpu_ready, 0);
    check(!fl_rd, "R1", "fl_rd after reset", fl_rd, 0);

    for (int i = 0; i < 12; i++) begin
      fetch(TBL[i].addr, TBL[i].sz, lat, d, rd);
      check(d == exp_data(TBL[i].addr, TBL[i].sz), $sformatf("R%0d", TBL[i].req),
            $sformatf("data vec %0d", i), d, exp_data(TBL[i].addr, TBL[i].sz));
      if (TBL[i].lat != 0)
        check(lat == int'(TBL[i].lat), $sformatf("R%0d", TBL[i].req),
              $sformatf("latency vec %0d", i), lat, TBL[i].lat);
      check(rd == int'(TBL[i].rd), $sformatf("R%0d", TBL[i].req),
            $sformatf("flash reads vec %0d", i), rd, TBL[i].rd);
    end

    // R6: longer wait states on a demand miss
    idle(10); ws = 4'd5;
    fetch(16'h0400, 1'b0, lat, d, rd);
    check(lat == 8, "R6", "miss latency ws5", lat, 8);
    check(d == exp_data(16'h0400, 1'b0), "R6", "data ws5", d, exp_data(16'h0400, 1'b0));

    // R9: older word still held while the next is prefetched
    idle(15); ws = 4'd8;
    fetch(16'h0600, 1'b0, lat, d, rd);
    check(lat == 11, "R6", "miss latency ws8", lat, 11);
    idle(12);
    fetch(16'h0604, 1'b0, lat, d, rd);
    check(lat == 1 && rd == 0, "R9", "prefetched word hit", lat, 1);
    fetch(16'h0602, 1'b0, lat, d, rd);
    check(lat == 1, "R9", "back-fetch latency", lat, 1);
    check(rd == 0, "R9", "back-fetch reads", rd, 0);
    check(d == exp_data(16'h0602, 1'b0), "R9", "back-fetch data", d, exp_data(16'h0602, 1'b0));

    // R1: reset in the middle of a read, then a previously held word misses
    rst = 1'b1; idle(2); rst = 1'b0;
    @(negedge clk);
    check(!cpu_ready && !fl_rd, "R1", "quiet after mid-read reset", {cpu_ready, fl_rd}, 0);
    fetch(16'h0604, 1'b0, lat, d, rd);
    check(rd == 1, "R1", "first fetch after reset reads flash", rd, 1);
    check(lat == 11, "R1", "miss latency after reset", lat, 11);
    check(d == exp_data(16'h0604, 1'b0), "R2", "data after reset", d, exp_data(16'h0604, 1'b0));

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R8 global watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule